// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

The resolver chooses which one of eight interrupt lines should be offered to the processor next. Each line has a pending-request bit, a mask bit and an in-service bit. Priority rotates: a three-bit base register names the line that currently ranks highest. The other lines follow it in ascending order and wrap around, so line `(base + k) mod 8` has priority `k`, and a smaller number means a more urgent line. A line is a candidate when it is requested and not masked. The best candidate is reported only when its priority is strictly better than that of the most urgent line already in service. This keeps nested servicing correct.

When an instance acts as the master of a cascaded pair and nested mode is turned on, the in-service bit of the cascade line (line 2) takes no part in the in-service comparison. A second request from the downstream controller can then get through while the cascade line is still being serviced.

The selection logic is combinational. It reads the request, mask and in-service inputs directly, together with the registered base, so the outcome is visible in the same cycle that the inputs change. Three events can load the base register:
- a direct load of a value;
- a specific rotation, which makes the line after a named line the most urgent;
- a rotate-on-end-of-interrupt, which makes the line after the most urgent in-service line the most urgent.

There is no data stream here, so every pin is a plain level signal with no handshake.

Top module: `rot_prio_resolver`

## Requirements
- R1: Only a line whose `req_i` bit is 1 and whose `mask_i` bit is 0 can be reported. A set mask bit always keeps its line from winning.
- R2: A line's priority is `(line - base_o) mod 8`. The line equal to `base_o` ranks highest, and the winner is the candidate with the smallest priority.
- R3: `irq_valid_o` is 1 only when the best candidate's priority is strictly less than the best priority among the in-service lines. An in-service line blocks every candidate of equal or lower urgency, including itself.
- R4: When no line is a candidate, `irq_valid_o` is 0.
- R5: When `nested_en_i` and `is_master_i` are both 1, `insvc_i[2]` is left out of the in-service comparison. In every other case all eight in-service bits take part.
- R6: When `irq_valid_o` is 1, `irq_line_o` equals `(winning priority + base_o) mod 8`, which is the absolute line number.
- R7: Reset sets `base_o` to 0, so line 0 starts as the most urgent line.
- R8: A cycle with `base_ld_i` = 1 sets `base_o` to `base_val_i` at the next clock edge.
- R9: A cycle with `spec_rot_i` = 1 and no direct load sets `base_o` to `(spec_line_i + 1) mod 8` at the next clock edge.
- R10: A cycle with `eoi_rot_i` = 1 and no higher-ranked load does one of two things at the next clock edge:
  - if any `insvc_i` bit is set, it sets `base_o` to one more (mod 8) than the most urgent in-service line, judged against the current base over all eight bits;
  - if no `insvc_i` bit is set, it leaves `base_o` unchanged.
- R11: Base loads are ranked: a direct load beats a specific rotation, and a specific rotation beats an end-of-interrupt rotation. With none of the three active, `base_o` holds its value.
- R12: `irq_valid_o` and `irq_line_o` follow `req_i`, `mask_i`, `insvc_i`, `nested_en_i` and `is_master_i` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_i | input | 8 | Pending request per line |
| mask_i | input | 8 | Mask per line, 1 = masked |
| insvc_i | input | 8 | In-service per line |
| nested_en_i | input | 1 | Nested mode enable |
| is_master_i | input | 1 | Instance is the cascade master |
| base_ld_i | input | 1 | Load base directly |
| base_val_i | input | 3 | Value for direct load |
| spec_rot_i | input | 1 | Rotate after a named line |
| spec_line_i | input | 3 | Line named for specific rotation |
| eoi_rot_i | input | 1 | Rotate after the most urgent in-service line |
| irq_valid_o | output | 1 | A line should be presented |
| irq_line_o | output | 3 | Winning line number |
| base_o | output | 3 | Current rotation base |

## Verification
The winner and its valid flag are due in the same cycle as the inputs that produce them. The bench therefore drives those inputs at the falling edge and samples one nanosecond later, before any rising edge can intervene. Each base load is due one rising edge after it is requested. The bench holds the load strobe for exactly one falling-to-falling interval and reads `base_o` at the next falling edge. Every result that depends on the base is checked only after that base has been read back, so a rotation and a selection are never judged in the same sample.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // Line that carries the downstream controller in a cascade.
  localparam int unsigned CASCADE_LINE = 2;

  // Source chosen for the next base value, highest rank first in value.
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_EOI    = 2'd1,
    SRC_SPEC   = 2'd2,
    SRC_DIRECT = 2'd3
  } base_src_e;

endpackage

// File: rtl/rpr_prio_find.sv
// Rotated priority search: finds the set bit of vec_i nearest to base_i,
// walking upward with wrap. prio_o = N when vec_i is empty.
module rpr_prio_find #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned PW = IW + 1
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic [PW-1:0] prio_o,
  output logic [IW-1:0] line_o
);

  logic [N-1:0] rot;

  // rot[k] is the bit that has relative priority k.
  for (genvar k = 0; k < N; k++) begin : g_rot
    logic [IW-1:0] idx;
    assign idx    = base_i + IW'(k);
    assign rot[k] = vec_i[idx];
  end

  always_comb begin
    prio_o = PW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) prio_o = PW'(k);
    end
  end

  assign line_o = prio_o[IW-1:0] + base_i;

  // R6: a reported position is really set in the searched vector.
  always_comb begin
    if (prio_o < PW'(N)) begin
      p_hit_is_set_r6: assert (vec_i[line_o])
        else $error("prio_find reported an unset line");
    end
  end

  // R4: empty result only for an empty vector.
  always_comb begin
    if (prio_o == PW'(N)) begin
      p_empty_vec_r4: assert (vec_i == '0)
        else $error("prio_find missed a set line");
    end
  end

endmodule

// File: rtl/rpr_base_reg.sv
// Rotation base register with ranked load sources.
module rpr_base_reg
  import rpr_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [IW-1:0] ld_val_i,
  input  logic          spec_i,
  input  logic [IW-1:0] spec_line_i,
  input  logic          eoi_i,
  input  logic [N-1:0]  isr_i,
  output logic [IW-1:0] base_o
);

  logic [PW-1:0] top_prio;
  logic [IW-1:0] top_line;
  logic          isr_any;
  base_src_e     src;
  logic [IW-1:0] base_nxt;

  // Most urgent in-service line over all bits, for end-of-interrupt rotation.
  rpr_prio_find #(.N(N)) i_isr_top (
    .vec_i (isr_i),
    .base_i(base_o),
    .prio_o(top_prio),
    .line_o(top_line)
  );

  assign isr_any = ~top_prio[PW-1];

  always_comb begin
    if (ld_i)                  src = SRC_DIRECT;
    else if (spec_i)           src = SRC_SPEC;
    else if (eoi_i && isr_any) src = SRC_EOI;
    else                       src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_DIRECT: base_nxt = ld_val_i;
      SRC_SPEC:   base_nxt = spec_line_i + IW'(1);
      SRC_EOI:    base_nxt = top_line + IW'(1);
      default:    base_nxt = base_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) base_o <= '0;
    else        base_o <= base_nxt;
  end

  p_direct_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> base_o == $past(ld_val_i));

  p_spec_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && spec_i) |=> base_o == $past(spec_line_i) + IW'(1));

  p_eoi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !spec_i && eoi_i && isr_i == '0) |=> $stable(base_o));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !spec_i && !eoi_i) |=> $stable(base_o));

endmodule

// File: rtl/rot_prio_resolver.sv
// Top: candidate search, in-service search and strict comparison.
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  insvc_i,
  input  logic          nested_en_i,
  input  logic          is_master_i,
  input  logic          base_ld_i,
  input  logic [IW-1:0] base_val_i,
  input  logic          spec_rot_i,
  input  logic [IW-1:0] spec_line_i,
  input  logic          eoi_rot_i,
  output logic          irq_valid_o,
  output logic [IW-1:0] irq_line_o,
  output logic [IW-1:0] base_o
);

  logic [N-1:0]  cand;
  logic [N-1:0]  insvc_eff;
  logic          cascade_exempt;
  logic [PW-1:0] cand_prio;
  logic [PW-1:0] cur_prio;
  logic [IW-1:0] cur_line;

  rpr_base_reg #(.N(N)) i_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (base_ld_i),
    .ld_val_i   (base_val_i),
    .spec_i     (spec_rot_i),
    .spec_line_i(spec_line_i),
    .eoi_i      (eoi_rot_i),
    .isr_i      (insvc_i),
    .base_o     (base_o)
  );

  assign cand           = req_i & ~mask_i;
  assign cascade_exempt = nested_en_i & is_master_i;

  for (genvar i = 0; i < N; i++) begin : g_isr_eff
    if (i == CASCADE_LINE) begin : g_casc
      assign insvc_eff[i] = insvc_i[i] & ~cascade_exempt;
    end else begin : g_plain
      assign insvc_eff[i] = insvc_i[i];
    end
  end

  rpr_prio_find #(.N(N)) i_cand (
    .vec_i (cand),
    .base_i(base_o),
    .prio_o(cand_prio),
    .line_o(irq_line_o)
  );

  rpr_prio_find #(.N(N)) i_cur (
    .vec_i (insvc_eff),
    .base_i(base_o),
    .prio_o(cur_prio),
    .line_o(cur_line)
  );

  // Empty candidate set yields N, never below cur_prio (at most N).
  assign irq_valid_o = cand_prio < cur_prio;

  p_cand_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (req_i[irq_line_o] && !mask_i[irq_line_o]));

  p_base_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[base_o] && !mask_i[base_o] && !insvc_i[base_o])
      |-> (irq_valid_o && irq_line_o == base_o));

  p_not_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !(cascade_exempt && irq_line_o == IW'(CASCADE_LINE)))
      |-> !insvc_i[irq_line_o]);

  p_base_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_i[base_o] && !(cascade_exempt && base_o == IW'(CASCADE_LINE)))
      |-> !irq_valid_o);

  p_blocker_real_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_prio != PW'(N))
      |-> (insvc_i[cur_line] && !(cascade_exempt && cur_line == IW'(CASCADE_LINE))));

  p_no_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !irq_valid_o);

endmodule

// File: tb/test_rot_prio_resolver.sv
`timescale 1ns/1ps
module test_rot_prio_resolver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, insvc = '0;
  logic       nested = 1'b0, master = 1'b0;
  logic       ld = 1'b0, spec = 1'b0, eoi = 1'b0;
  logic [2:0] ld_val = '0, spec_line = '0;
  logic       irq_valid;
  logic [2:0] irq_line, base;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  rot_prio_resolver i_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(insvc),
    .nested_en_i(nested), .is_master_i(master), .base_ld_i(ld),
    .base_val_i(ld_val), .spec_rot_i(spec), .spec_line_i(spec_line),
    .eoi_rot_i(eoi), .irq_valid_o(irq_valid), .irq_line_o(irq_line),
    .base_o(base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference selection: {valid, line}.
  function automatic logic [3:0] ref_pick(input logic [7:0] r, m, s,
                                          input logic [2:0] b, input logic n, ma);
    logic [7:0] c, e;
    int cp, sp;
    c = r & ~m;
    e = s;
    if (n && ma) e[2] = 1'b0;
    cp = 8; sp = 8;
    for (int k = 7; k >= 0; k--) begin
      if (c[(b + k) % 8]) cp = k;
      if (e[(b + k) % 8]) sp = k;
    end
    if (cp < sp) return {1'b1, 3'((cp + b) % 8)};
    return 4'b0000;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic apply(input logic [7:0] r, m, s, input logic n, ma);
    @(negedge clk);
    req = r; mask = m; insvc = s; nested = n; master = ma;
    #1;
  endtask

  // Compares the outcome with the reference; R12: sampled 1 ns after the change.
  task automatic cmp_sel(input string tag);
    logic [3:0] e;
    e = ref_pick(req, mask, insvc, base, nested, master);
    chk({tag, " valid"}, {31'd0, irq_valid}, {31'd0, e[3]});
    if (e[3]) chk({tag, " line"}, {29'd0, irq_line}, {29'd0, e[2:0]});
  endtask

  task automatic pulse(input logic l, input logic [2:0] lv,
                       input logic sp, input logic [2:0] sl, input logic eo);
    @(negedge clk);
    ld = l; ld_val = lv; spec = sp; spec_line = sl; eoi = eo;
    @(negedge clk);
    ld = 0; spec = 0; eoi = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 base in reset", {29'd0, base}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 base after reset", {29'd0, base}, 0);
    chk("R4 idle no valid", {31'd0, irq_valid}, 0);
    apply(8'hFF, 8'h00, 8'h00, 0, 0);
    chk("R7 line0 first", {28'd0, irq_valid, irq_line}, 4'b1000);

    // Sweep every base with random patterns (R1 R2 R3 R5 R6 R12).
    for (int b = 0; b < 8; b++) begin
      pulse(1, 3'(b), 0, 0, 0);
      chk("R8 direct load", {29'd0, base}, b);
      for (int i = 0; i < 8; i++) begin
        apply(8'(1 << i), 8'h00, 8'h00, 0, 0);
        chk("R6 single line", {28'd0, irq_valid, irq_line}, {28'd0, 1'b1, 3'(i)});
      end
      apply(8'hFF, 8'h00, 8'h00, 0, 0);
      chk("R2 base ranks first", {28'd0, irq_valid, irq_line}, {28'd0, 1'b1, 3'(b)});
      apply(8'hFF, 8'h00, 8'(1 << b), 0, 0);
      if (b != 2) chk("R3 base in service blocks", {31'd0, irq_valid}, 0);
      for (int t = 0; t < 300; t++) begin
        logic [31:0] v;
        v = rnd();
        apply(v[7:0], v[15:8] & v[31:24], v[23:16] & v[27:20], v[28], v[29]);
        cmp_sel("R1 R3 R5 R6 R12 sweep");
      end
    end

    // Masking (R1, R4).
    pulse(1, 3'd0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      apply(8'hFF, ~8'(1 << i), 8'h00, 0, 0);
      chk("R1 only unmasked wins", {28'd0, irq_valid, irq_line}, {28'd0, 1'b1, 3'(i)});
    end
    apply(8'hFF, 8'hFF, 8'h00, 0, 0);
    chk("R4 all masked", {31'd0, irq_valid}, 0);
    apply(8'h10, 8'h00, 8'h10, 0, 0);
    chk("R3 equal priority blocked", {31'd0, irq_valid}, 0);

    // Nested cascade exemption (R5).
    apply(8'h08, 8'h00, 8'h04, 0, 1);
    chk("R5 master not nested blocked", {31'd0, irq_valid}, 0);
    apply(8'h08, 8'h00, 8'h04, 1, 0);
    chk("R5 nested non-master blocked", {31'd0, irq_valid}, 0);
    apply(8'h08, 8'h00, 8'h04, 1, 1);
    chk("R5 nested master passes", {28'd0, irq_valid, irq_line}, 4'b1011);
    apply(8'h04, 8'h00, 8'h04, 1, 1);
    chk("R5 cascade re-request", {28'd0, irq_valid, irq_line}, 4'b1010);
    apply(8'h08, 8'h00, 8'h06, 1, 1);
    chk("R5 other bits still count", {31'd0, irq_valid}, 0);

    // Specific rotation (R9).
    for (int i = 0; i < 8; i++) begin
      pulse(0, 0, 1, 3'(i), 0);
      chk("R9 specific rotate", {29'd0, base}, (i + 1) % 8);
    end

    // End-of-interrupt rotation (R10).
    pulse(1, 3'd3, 0, 0, 0);
    apply(8'h00, 8'h00, 8'h81, 0, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R10 eoi after line7", {29'd0, base}, 0);
    apply(8'h00, 8'h00, 8'h24, 1, 1);
    pulse(0, 0, 0, 0, 1);
    chk("R10 eoi uses raw bit2", {29'd0, base}, 3);
    apply(8'h00, 8'h00, 8'h00, 0, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R10 eoi empty holds", {29'd0, base}, 3);

    // Load ranking (R11).
    apply(8'h00, 8'h00, 8'h02, 0, 0);
    pulse(1, 3'd6, 1, 3'd1, 1);
    chk("R11 direct wins", {29'd0, base}, 6);
    pulse(0, 0, 1, 3'd4, 1);
    chk("R11 specific beats eoi", {29'd0, base}, 5);
    pulse(0, 0, 0, 0, 0);
    chk("R11 hold", {29'd0, base}, 5);
    apply(8'hFF, 8'h00, 8'h00, 0, 0);
    chk("R2 rotated base wins", {28'd0, irq_valid, irq_line}, 4'b1101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule